// File: doc/BRIEF.md
# Dual-Field Video Timing Generator

This block drives the raster timing of a video output. Two counters walk every line and every frame: one counts output clocks and one counts lines. From their positions the block produces horizontal and vertical sync, horizontal and vertical blanking, and a data-enable strobe. All horizontal lengths are in output clocks. Software that repeats pixels programs counts that are already multiplied by the repetition factor (1 or 2), so the block needs no repetition logic of its own.

For interlaced output the block alternates between two sets of vertical parameters, one per field, and reports the current field on a pin. The usual programming makes the second field's back porch one line shorter than the first field's. All timing inputs go through shadow registers, so software can rewrite them at any time without tearing the current field. Each sync pin has two polarity controls. The block also keeps a field counter that can be cleared, and it flags a pixel-source underflow during active video when that check is enabled.

Each line runs in this order: active, front porch, sync, back porch. Each field runs in the same order, counted in lines. The block carries no pixel data stream, so it has no valid/ready interface. Every pin is a plain level.

Top module: `vid_timing_gen`

## Requirements
- R1: The line length is act+front+sync+back clocks and the field length is the same sum in lines. `de_o` is high exactly when the horizontal position is below `h_act` and the line is below the current field's active count. `hblank_o` is the inverse of the horizontal active condition and `vblank_o` is the inverse of the vertical one.
- R2: The internal horizontal sync is true for positions h_act+h_fp up to, but not including, h_act+h_fp+h_sw.
- R3: Let S = act+fp of the current field and E = S+sw. Vertical sync starts on line S at pixel position `v_ofs` and ends on line E at pixel position `v_ofs`. The back porch must be at least one line and sync at least one line.
- R4: Each sync pin carries the internal sync XOR (NOT its positive bit) XOR its active-low control. The positive bits are shadowed. `hs_low` and `vs_low` act at once.
- R5: Index 0 of the vertical sets is the first field and index 1 is the second. At each field wrap, `field_o` toggles if `interlace` is 1 and goes to 0 otherwise. The current field's set governs that field.
- R6: The timing inputs (horizontal, both vertical sets, the positive bits) are captured while `run` is low and at the last clock of the last line. A change made in the middle of a field has no effect until the next field.
- R7: While `run` is low, both counters sit at position 0, `de_o` is 0, both blanks are 1, both internal syncs are false and `field_o` is 0. In the first cycle after `run` rises, the outputs show position (0,0).
- R8: `fcnt_o` counts field wraps modulo 2^FCW. A `fcnt_clr` pulse makes it 0 at the next edge and takes priority over an increment.
- R9: `underflow_o` is high for the cycle after one in which `uf_en`, `de_o` and `fifo_empty` are all high, and low otherwise.
- R10: Under reset the counters, field, field counter, underflow flag and shadows are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the timing counters |
| interlace | input | 1 | Alternates fields at each field wrap |
| h_act | input | HW | Active clocks per line |
| h_fp | input | HW | Horizontal front porch |
| h_sw | input | HW | Horizontal sync width |
| h_bp | input | HW | Horizontal back porch |
| hs_pos | input | 1 | Horizontal sync is positive |
| vs_pos | input | 1 | Vertical sync is positive |
| v_act | input | 2xVW | Active lines per set |
| v_fp | input | 2xVW | Vertical front porch per set |
| v_sw | input | 2xVW | Vertical sync lines per set |
| v_bp | input | 2xVW | Vertical back porch per set |
| v_ofs | input | 2xHW | Pixel offset of the vertical sync edges per set |
| hs_low | input | 1 | Inverts the horizontal sync pin |
| vs_low | input | 1 | Inverts the vertical sync pin |
| fcnt_clr | input | 1 | Clears the field counter |
| uf_en | input | 1 | Enables underflow detection |
| fifo_empty | input | 1 | The pixel source has no data |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Active video strobe |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| field_o | output | 1 | Current field index |
| fcnt_o | output | FCW | Field counter |
| underflow_o | output | 1 | Underflow seen in the previous cycle |

## Verification
The assertions check several rules on every cycle:
- both counters stay inside the programmed totals;
- the field index holds in the middle of a field and stays 0 in progressive mode;
- the field counter only clears or steps at a wrap;
- `de_o` never appears during blanking.

Other behaviour only the bench's scenarios can show, by stepping a position model alongside the block:
- the exact sync edges, including the pixel offset of the vertical edges;
- the polarity combinations;
- the per-field back porch;
- the deferral of a mid-field reprogramming.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    SEG_ACT   = 2'd0,
    SEG_FRONT = 2'd1,
    SEG_SYNC  = 2'd2,
    SEG_BACK  = 2'd3
  } seg_e;
endpackage

// File: rtl/vtg_axis_ctr.sv
module vtg_axis_ctr
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  localparam int TW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_front,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  output logic [TW-1:0] pos,
  output logic          at_end,
  output seg_e          seg
);
  logic [TW-1:0] b_front, b_sync, b_back, total;

  assign b_front = {2'b00, len_act};
  assign b_sync  = b_front + {2'b00, len_front};
  assign b_back  = b_sync + {2'b00, len_sync};
  assign total   = b_back + {2'b00, len_back};
  assign at_end  = run && (pos == total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (!run)   pos <= '0;
    else if (step)   pos <= at_end ? '0 : pos + 1'b1;
  end

  always_comb begin
    if (pos < b_front)     seg = SEG_ACT;
    else if (pos < b_sync) seg = SEG_FRONT;
    else if (pos < b_back) seg = SEG_SYNC;
    else                   seg = SEG_BACK;
  end

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos < total));
endmodule

// File: rtl/vtg_field_seq.sv
module vtg_field_seq #(
  parameter int HW  = 12,
  parameter int VW  = 11,
  parameter int FCW = 8,
  localparam int NSET = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    wrap,
  input  logic                    fcnt_clr,
  input  logic                    interlace,
  input  logic [HW-1:0]           h_act,
  input  logic [HW-1:0]           h_fp,
  input  logic [HW-1:0]           h_sw,
  input  logic [HW-1:0]           h_bp,
  input  logic                    hs_pos,
  input  logic                    vs_pos,
  input  logic [NSET-1:0][VW-1:0] v_act,
  input  logic [NSET-1:0][VW-1:0] v_fp,
  input  logic [NSET-1:0][VW-1:0] v_sw,
  input  logic [NSET-1:0][VW-1:0] v_bp,
  input  logic [NSET-1:0][HW-1:0] v_ofs,
  output logic [HW-1:0]           sh_h_act,
  output logic [HW-1:0]           sh_h_fp,
  output logic [HW-1:0]           sh_h_sw,
  output logic [HW-1:0]           sh_h_bp,
  output logic                    sh_hs_pos,
  output logic                    sh_vs_pos,
  output logic [VW-1:0]           cur_v_act,
  output logic [VW-1:0]           cur_v_fp,
  output logic [VW-1:0]           cur_v_sw,
  output logic [VW-1:0]           cur_v_bp,
  output logic [HW-1:0]           cur_v_ofs,
  output logic                    field,
  output logic [FCW-1:0]          fcnt
);
  logic load;
  logic [NSET-1:0][VW-1:0] s_act, s_fp, s_sw, s_bp;
  logic [NSET-1:0][HW-1:0] s_ofs;

  assign load = !run || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_h_act  <= '0;
      sh_h_fp   <= '0;
      sh_h_sw   <= '0;
      sh_h_bp   <= '0;
      sh_hs_pos <= 1'b0;
      sh_vs_pos <= 1'b0;
    end else if (load) begin
      sh_h_act  <= h_act;
      sh_h_fp   <= h_fp;
      sh_h_sw   <= h_sw;
      sh_h_bp   <= h_bp;
      sh_hs_pos <= hs_pos;
      sh_vs_pos <= vs_pos;
    end
  end

  for (genvar g = 0; g < NSET; g++) begin : g_vset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_act[g] <= '0;
        s_fp[g]  <= '0;
        s_sw[g]  <= '0;
        s_bp[g]  <= '0;
        s_ofs[g] <= '0;
      end else if (load) begin
        s_act[g] <= v_act[g];
        s_fp[g]  <= v_fp[g];
        s_sw[g]  <= v_sw[g];
        s_bp[g]  <= v_bp[g];
        s_ofs[g] <= v_ofs[g];
      end
    end
  end

  assign cur_v_act = s_act[field];
  assign cur_v_fp  = s_fp[field];
  assign cur_v_sw  = s_sw[field];
  assign cur_v_bp  = s_bp[field];
  assign cur_v_ofs = s_ofs[field];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      field <= 1'b0;
    else if (!run)   field <= 1'b0;
    else if (wrap)   field <= interlace ? ~field : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fcnt <= '0;
    else if (fcnt_clr)       fcnt <= '0;
    else if (run && wrap)    fcnt <= fcnt + 1'b1;
  end

  // R5
  prog_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap && !interlace) |=> !field);
  // R5
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(field));
  // R8
  fcnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_clr |=> (fcnt == '0));
  // R8
  fcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fcnt_clr && !(run && wrap)) |=> $stable(fcnt));
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int HW  = 12,
  parameter int VW  = 11,
  parameter int FCW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              interlace,
  input  logic [HW-1:0]     h_act,
  input  logic [HW-1:0]     h_fp,
  input  logic [HW-1:0]     h_sw,
  input  logic [HW-1:0]     h_bp,
  input  logic              hs_pos,
  input  logic              vs_pos,
  input  logic [1:0][VW-1:0] v_act,
  input  logic [1:0][VW-1:0] v_fp,
  input  logic [1:0][VW-1:0] v_sw,
  input  logic [1:0][VW-1:0] v_bp,
  input  logic [1:0][HW-1:0] v_ofs,
  input  logic              hs_low,
  input  logic              vs_low,
  input  logic              fcnt_clr,
  input  logic              uf_en,
  input  logic              fifo_empty,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              field_o,
  output logic [FCW-1:0]    fcnt_o,
  output logic              underflow_o
);
  localparam int HTW = HW + 2;
  localparam int VTW = VW + 2;

  logic [HW-1:0]  sh_h_act, sh_h_fp, sh_h_sw, sh_h_bp, cur_v_ofs;
  logic [VW-1:0]  cur_v_act, cur_v_fp, cur_v_sw, cur_v_bp;
  logic           sh_hs_pos, sh_vs_pos, field, h_end, v_end, wrap;
  logic [HTW-1:0] h_pos;
  logic [VTW-1:0] v_pos, v_sync_top, v_sync_bot;
  seg_e           h_seg, v_seg;
  logic           h_act_now, v_act_now, in_hs, in_vs, before_ofs;

  assign wrap = h_end && v_end;

  vtg_field_seq #(.HW(HW), .VW(VW), .FCW(FCW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .wrap      (wrap),
    .fcnt_clr  (fcnt_clr),
    .interlace (interlace),
    .h_act     (h_act),
    .h_fp      (h_fp),
    .h_sw      (h_sw),
    .h_bp      (h_bp),
    .hs_pos    (hs_pos),
    .vs_pos    (vs_pos),
    .v_act     (v_act),
    .v_fp      (v_fp),
    .v_sw      (v_sw),
    .v_bp      (v_bp),
    .v_ofs     (v_ofs),
    .sh_h_act  (sh_h_act),
    .sh_h_fp   (sh_h_fp),
    .sh_h_sw   (sh_h_sw),
    .sh_h_bp   (sh_h_bp),
    .sh_hs_pos (sh_hs_pos),
    .sh_vs_pos (sh_vs_pos),
    .cur_v_act (cur_v_act),
    .cur_v_fp  (cur_v_fp),
    .cur_v_sw  (cur_v_sw),
    .cur_v_bp  (cur_v_bp),
    .cur_v_ofs (cur_v_ofs),
    .field     (field),
    .fcnt      (fcnt_o)
  );

  vtg_axis_ctr #(.CW(HW)) u_hctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .step      (1'b1),
    .len_act   (sh_h_act),
    .len_front (sh_h_fp),
    .len_sync  (sh_h_sw),
    .len_back  (sh_h_bp),
    .pos       (h_pos),
    .at_end    (h_end),
    .seg       (h_seg)
  );

  vtg_axis_ctr #(.CW(VW)) u_vctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .step      (h_end),
    .len_act   (cur_v_act),
    .len_front (cur_v_fp),
    .len_sync  (cur_v_sw),
    .len_back  (cur_v_bp),
    .pos       (v_pos),
    .at_end    (v_end),
    .seg       (v_seg)
  );

  // vertical sync edges move to a pixel offset inside the boundary lines
  assign v_sync_top = {2'b00, cur_v_act} + {2'b00, cur_v_fp};
  assign v_sync_bot = v_sync_top + {2'b00, cur_v_sw};
  assign before_ofs = h_pos < {2'b00, cur_v_ofs};

  assign h_act_now = run && (h_seg == SEG_ACT);
  assign v_act_now = run && (v_seg == SEG_ACT);
  assign in_hs     = run && (h_seg == SEG_SYNC);
  assign in_vs     = run && (((v_seg == SEG_SYNC) && !((v_pos == v_sync_top) && before_ofs))
                          || ((v_pos == v_sync_bot) && before_ofs));

  assign hsync_o  = in_hs ^ ~sh_hs_pos ^ hs_low;
  assign vsync_o  = in_vs ^ ~sh_vs_pos ^ vs_low;
  assign de_o     = h_act_now && v_act_now;
  assign hblank_o = !h_act_now;
  assign vblank_o = !v_act_now;
  assign field_o  = field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underflow_o <= 1'b0;
    else        underflow_o <= uf_en && de_o && fifo_empty;
  end

  // R1
  de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (!hblank_o && !vblank_o));
  // R7
  idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> ((h_pos == '0) && (v_pos == '0)));
  // R9
  uf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf_en) |=> !underflow_o);
endmodule

// File: tb/vid_timing_gen_bench.sv
module vid_timing_gen_bench;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int FCW = 8;
  localparam int NCFG = 4;
  // ha hfp hsw hbp hpos vpos hlow vlow va vfp vsw vbp ilace ofs cycles
  localparam int CFG [NCFG][15] = '{
    '{8, 2, 3, 4, 1, 1, 0, 0, 5, 1, 2, 2, 0, 0, 600},
    '{6, 1, 2, 3, 0, 0, 0, 0, 4, 2, 1, 3, 1, 3, 700},
    '{10, 3, 2, 1, 1, 0, 1, 1, 3, 1, 1, 2, 1, 5, 500},
    '{5, 1, 1, 1, 0, 1, 1, 0, 2, 1, 1, 1, 0, 2, 300}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, interlace = 1'b0;
  logic [HW-1:0] h_act = '0, h_fp = '0, h_sw = '0, h_bp = '0;
  logic hs_pos = 1'b0, vs_pos = 1'b0, hs_low = 1'b0, vs_low = 1'b0;
  logic [1:0][VW-1:0] v_act = '0, v_fp = '0, v_sw = '0, v_bp = '0;
  logic [1:0][HW-1:0] v_ofs = '0;
  logic fcnt_clr = 1'b0, uf_en = 1'b0, fifo_empty = 1'b0;
  logic hsync_o, vsync_o, de_o, hblank_o, vblank_o, field_o, underflow_o;
  logic [FCW-1:0] fcnt_o;

  always #5 clk = ~clk;

  vid_timing_gen #(.HW(HW), .VW(VW), .FCW(FCW)) u_vid_timing_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .interlace(interlace),
    .h_act(h_act), .h_fp(h_fp), .h_sw(h_sw), .h_bp(h_bp),
    .hs_pos(hs_pos), .vs_pos(vs_pos),
    .v_act(v_act), .v_fp(v_fp), .v_sw(v_sw), .v_bp(v_bp), .v_ofs(v_ofs),
    .hs_low(hs_low), .vs_low(vs_low), .fcnt_clr(fcnt_clr),
    .uf_en(uf_en), .fifo_empty(fifo_empty),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .field_o(field_o),
    .fcnt_o(fcnt_o), .underflow_o(underflow_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string ctx = "";

  // position model
  int mh = 0, mv = 0, mf = 0, m_fc = 0;
  bit m_uf = 0;
  int s_ha = 0, s_hfp = 0, s_hsw = 0, s_hbp = 0;
  bit s_hpos = 0, s_vpos = 0;
  int s_va[2] = '{0, 0}, s_vfp[2] = '{0, 0}, s_vsw[2] = '{0, 0}, s_vbp[2] = '{0, 0}, s_ofs[2] = '{0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, ctx, act, exp, $time);
    end
  endtask

  function automatic bit e_de();
    return run && (mh < s_ha) && (mv < s_va[mf]);
  endfunction

  task automatic compare();
    bit hact, vact, ihs, ivs, ehs, evs;
    int ss, se;
    hact = run && (mh < s_ha);
    vact = run && (mv < s_va[mf]);
    ihs  = run && (mh >= s_ha + s_hfp) && (mh < s_ha + s_hfp + s_hsw);
    ss   = s_va[mf] + s_vfp[mf];
    se   = ss + s_vsw[mf];
    ivs  = run && (((mv >= ss) && (mv < se) && !((mv == ss) && (mh < s_ofs[mf])))
                || ((mv == se) && (mh < s_ofs[mf])));
    ehs  = ihs ^ !s_hpos ^ hs_low;
    evs  = ivs ^ !s_vpos ^ vs_low;
    chk(de_o == (hact && vact), "R1 de", int'(de_o), int'(hact && vact));
    chk(hblank_o == !hact, "R1 hblank", int'(hblank_o), int'(!hact));
    chk(vblank_o == !vact, "R1 vblank", int'(vblank_o), int'(!vact));
    chk(hsync_o == ehs, "R2/R4 hsync", int'(hsync_o), int'(ehs));
    chk(vsync_o == evs, "R3/R4 vsync", int'(vsync_o), int'(evs));
    chk(field_o == mf[0], "R5 field", int'(field_o), mf);
    chk(int'(fcnt_o) == m_fc, "R8 fcnt", int'(fcnt_o), m_fc);
    chk(underflow_o == m_uf, "R9 underflow", int'(underflow_o), int'(m_uf));
  endtask

  task automatic load_shadow();
    s_ha = h_act; s_hfp = h_fp; s_hsw = h_sw; s_hbp = h_bp;
    s_hpos = hs_pos; s_vpos = vs_pos;
    for (int k = 0; k < 2; k++) begin
      s_va[k] = v_act[k]; s_vfp[k] = v_fp[k]; s_vsw[k] = v_sw[k];
      s_vbp[k] = v_bp[k]; s_ofs[k] = v_ofs[k];
    end
  endtask

  task automatic edge_update();
    bit hl, vl, wr;
    int htot, vtot;
    m_uf = uf_en && e_de() && fifo_empty;
    htot = s_ha + s_hfp + s_hsw + s_hbp;
    vtot = s_va[mf] + s_vfp[mf] + s_vsw[mf] + s_vbp[mf];
    hl = (mh == htot - 1);
    vl = (mv == vtot - 1);
    wr = run && hl && vl;
    if (fcnt_clr) m_fc = 0;
    else if (wr) m_fc = (m_fc + 1) % (1 << FCW);
    if (!run) begin
      mh = 0; mv = 0; mf = 0;
    end else if (wr) begin
      mh = 0; mv = 0; mf = interlace ? 1 - mf : 0;
    end else if (hl) begin
      mh = 0; mv++;
    end else begin
      mh++;
    end
    if (!run || wr) load_shadow();
  endtask

  task automatic cyc();
    @(negedge clk);
    #2;
    compare();
    @(posedge clk);
    #1;
    edge_update();
  endtask

  task automatic apply_cfg(input int i);
    h_act = HW'(CFG[i][0]); h_fp = HW'(CFG[i][1]); h_sw = HW'(CFG[i][2]); h_bp = HW'(CFG[i][3]);
    hs_pos = CFG[i][4][0]; vs_pos = CFG[i][5][0]; hs_low = CFG[i][6][0]; vs_low = CFG[i][7][0];
    interlace = CFG[i][12][0];
    for (int k = 0; k < 2; k++) begin
      v_act[k] = VW'(CFG[i][8]); v_fp[k] = VW'(CFG[i][9]); v_sw[k] = VW'(CFG[i][10]);
      v_ofs[k] = HW'(CFG[i][13]);
    end
    v_bp[0] = VW'(CFG[i][11]);
    v_bp[1] = VW'(CFG[i][11] - CFG[i][12]); // second field one line shorter when interlaced
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    apply_cfg(0);
    // R10: reset state, shadows zero so sync pins idle at 1 ^ low
    #22;
    ctx = "reset";
    chk(de_o == 1'b0, "R10 de", int'(de_o), 0);
    chk(hblank_o && vblank_o, "R10 blank", int'(hblank_o && vblank_o), 1);
    chk(field_o == 1'b0, "R10 field", int'(field_o), 0);
    chk(fcnt_o == '0, "R10 fcnt", int'(fcnt_o), 0);
    chk(underflow_o == 1'b0, "R10 underflow", int'(underflow_o), 0);
    chk(hsync_o == 1'b1, "R10 hsync idle", int'(hsync_o), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    load_shadow();

    // table walk over modes (R1 R2 R3 R4 R5 R7 R8)
    for (int i = 0; i < NCFG; i++) begin
      ctx = $sformatf("cfg%0d", i);
      run = 1'b0;
      apply_cfg(i);
      cyc(); cyc();
      run = 1'b1;
      for (int c = 0; c < CFG[i][14]; c++) cyc();
    end

    // R6: mid-field reprogramming waits for the wrap
    ctx = "R6 shadow";
    run = 1'b0; apply_cfg(1); cyc(); cyc();
    run = 1'b1;
    for (int c = 0; c < 30; c++) cyc();
    h_act = 12'd4; h_sw = 12'd3; hs_pos = 1'b1; v_act[0] = 11'd2; v_act[1] = 11'd2;
    for (int c = 0; c < 400; c++) cyc();

    // R8: clear pulse
    ctx = "R8 clear";
    fcnt_clr = 1'b1; cyc(); fcnt_clr = 1'b0;
    chk(fcnt_o == '0, "R8 cleared", int'(fcnt_o), 0);
    for (int c = 0; c < 200; c++) cyc();

    // R9: underflow detection on and off
    ctx = "R9 underflow";
    uf_en = 1'b1; fifo_empty = 1'b1;
    for (int c = 0; c < 150; c++) cyc();
    uf_en = 1'b0;
    for (int c = 0; c < 20; c++) cyc();
    fifo_empty = 1'b0;

    // R7: drop run mid-field, outputs idle, restart at origin
    ctx = "R7 run";
    run = 1'b0;
    for (int c = 0; c < 5; c++) cyc();
    run = 1'b1;
    for (int c = 0; c < 60; c++) cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule